// File: doc/BRIEF.md
# Context-Switched Page Mapper with Protection

This block sits between a CPU and its memory system. It decodes a 24-bit CPU address into one of four equal regions: RAM, ROM, map storage and I/O. Addresses in the RAM region are logical. They are translated through a page table that holds one table per context. Each entry in the table gives a physical page number and two protection flags. The block also enforces access rights: user-state code may not touch the map or I/O regions, and it must honour the per-page flags.

The page table lives inside the block. The supervisor fills it by writing to the map region, and the entry data comes in on a side port. In supervisor state the block always translates through context 0. In user state it uses the context number supplied from the control register.

Each accepted request produces a one-cycle response two clock edges later. The response carries a region select, a physical address and a fault flag.

Top module: `ctx_page_mapper`

## Requirements
- R1: While reset is held and after it is released, `rsp_valid`, `rsp_fault` and all four region selects are 0 until a request is accepted.
- R2: A request sampled on a clock edge with `req_valid`=1 gives a response on the second following edge, with `rsp_valid` high for exactly one cycle. The region comes from address bits [23:22]: 00 is RAM, 01 is ROM, 10 is map and 11 is I/O. On a response without a fault, exactly the matching select is 1.
- R3: For a RAM access, `rsp_phys` = {entry physical page (9 bits), address bits [10:0]}. The logical page is address bits [20:11], and address bit 21 has no effect.
- R4: A supervisor access translates through context 0 whatever the value of `ctx_reg`. A user access translates through context `ctx_reg`.
- R5: A supervisor write to the map region stores `map_wdata` into the entry at context = address bits [13:11] and logical page = address bits [10:1]. The entry fields are: bits [8:0] the physical page, bit 9 write-protect, bit 10 no-access. A read of the map region changes no entry.
- R6: A user read or write of a RAM page whose no-access bit is 1 raises a fault.
- R7: A user write to a RAM page whose write-protect bit is 1 raises a fault. A user read of that page does not.
- R8: Supervisor accesses never fault, and in supervisor state the protection bits have no effect.
- R9: Any user access to the map or I/O region faults. A user write to the map region does not change the entry it addresses.
- R10: `rsp_fault` is high only together with `rsp_valid`. On a fault all four selects are 0 and `rsp_phys` is 0.
- R11: For a ROM access, `rsp_phys` = address bits [15:0], zero-extended. For map and I/O accesses, `rsp_phys` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 24 | CPU byte address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_super | input | 1 | 1 = supervisor state |
| ctx_reg | input | 3 | Context number used in user state |
| map_wdata | input | 11 | Entry data stored on a supervisor map write |
| rsp_valid | output | 1 | Response strobe |
| rsp_phys | output | 20 | Physical RAM or ROM address |
| rsp_sel_ram | output | 1 | RAM region select |
| rsp_sel_rom | output | 1 | ROM region select |
| rsp_sel_map | output | 1 | Map region select |
| rsp_sel_io | output | 1 | I/O region select |
| rsp_fault | output | 1 | Access violation |

## Verification
The bench builds the mapper with its default parameters: 8 contexts, 1024 logical pages of 2 KB, and a 9-bit physical page number. With these values the real field positions in the map-write address are exercised, and so is the aliasing of address bit 21 in the RAM region. The same entry index is loaded in two contexts, so the bench can show that supervisor state ignores `ctx_reg` while user state follows it. The no-access and write-protect pages are probed both as user and as supervisor, and a rejected user map write is read back through translation to show that it left the entry intact.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  typedef enum logic [1:0] {
    RG_RAM = 2'd0,
    RG_ROM = 2'd1,
    RG_MAP = 2'd2,
    RG_IO  = 2'd3
  } region_e;
endpackage

// File: rtl/map_store.sv
// Page-table storage: one inferable block RAM per context, synchronous read.
module map_store #(
  parameter int CTX_W   = 3,
  parameter int LPAGE_W = 10,
  parameter int ENT_W   = 11
) (
  input  logic               clk,
  input  logic               we,
  input  logic [CTX_W-1:0]   wctx,
  input  logic [LPAGE_W-1:0] wpage,
  input  logic [ENT_W-1:0]   wdata,
  input  logic               re,
  input  logic [CTX_W-1:0]   rctx,
  input  logic [LPAGE_W-1:0] rpage,
  output logic [ENT_W-1:0]   rdata
);
  localparam int NCTX  = 1 << CTX_W;
  localparam int DEPTH = 1 << LPAGE_W;

  logic [NCTX-1:0][ENT_W-1:0] bank_q;
  logic [CTX_W-1:0]           rctx_q;

  for (genvar g = 0; g < NCTX; g++) begin : g_bank
    logic [ENT_W-1:0] mem [DEPTH];
    logic [ENT_W-1:0] q;
    always_ff @(posedge clk) begin
      if (we && wctx == CTX_W'(g)) mem[wpage] <= wdata;
      if (re) q <= mem[rpage];
    end
    assign bank_q[g] = q;
  end

  always_ff @(posedge clk) begin
    if (re) rctx_q <= rctx;
  end

  assign rdata = bank_q[rctx_q];
endmodule

// File: rtl/access_check.sv
// Rights check and region select for one access.
module access_check
  import mapper_pkg::*;
(
  input  region_e    region,
  input  logic       is_write,
  input  logic       is_super,
  input  logic       no_access,
  input  logic       write_prot,
  output logic       fault,
  output logic [3:0] sel
);
  logic user_bad_region;
  logic user_bad_page;

  always_comb begin
    user_bad_region = (region == RG_MAP) || (region == RG_IO);
    user_bad_page   = (region == RG_RAM) && (no_access || (is_write && write_prot));
    fault           = !is_super && (user_bad_region || user_bad_page);
    sel             = '0;
    if (!fault) sel[region] = 1'b1;
  end
endmodule

// File: rtl/ctx_page_mapper.sv
module ctx_page_mapper
  import mapper_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int OFF_W   = 11,
  parameter int LPAGE_W = 10,
  parameter int PPAGE_W = 9,
  parameter int CTX_W   = 3,
  parameter int ROM_W   = 16,
  localparam int ENT_W  = PPAGE_W + 2,
  localparam int PHYS_W = PPAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_super,
  input  logic [CTX_W-1:0]  ctx_reg,
  input  logic [ENT_W-1:0]  map_wdata,
  output logic              rsp_valid,
  output logic [PHYS_W-1:0] rsp_phys,
  output logic              rsp_sel_ram,
  output logic              rsp_sel_rom,
  output logic              rsp_sel_map,
  output logic              rsp_sel_io,
  output logic              rsp_fault
);
  localparam int WP_BIT = PPAGE_W;
  localparam int NA_BIT = PPAGE_W + 1;

  // Stage 0: decode the request
  region_e            region0;
  logic [CTX_W-1:0]   eff_ctx;
  logic [LPAGE_W-1:0] lpage0;
  logic               map_we;
  logic [CTX_W-1:0]   wr_ctx;
  logic [LPAGE_W-1:0] wr_page;

  always_comb begin
    region0 = region_e'(req_addr[ADDR_W-1 -: 2]);
    eff_ctx = req_super ? '0 : ctx_reg;
    lpage0  = req_addr[OFF_W +: LPAGE_W];
    map_we  = req_valid && req_write && req_super && (region0 == RG_MAP);
    wr_ctx  = req_addr[LPAGE_W+1 +: CTX_W];
    wr_page = req_addr[1 +: LPAGE_W];
  end

  logic [ENT_W-1:0] entry;

  map_store #(.CTX_W(CTX_W), .LPAGE_W(LPAGE_W), .ENT_W(ENT_W)) u_store (
    .clk   (clk),
    .we    (map_we),
    .wctx  (wr_ctx),
    .wpage (wr_page),
    .wdata (map_wdata),
    .re    (req_valid),
    .rctx  (eff_ctx),
    .rpage (lpage0),
    .rdata (entry)
  );

  // Stage 1: request registers
  logic             s1_valid;
  region_e          s1_region;
  logic             s1_write;
  logic             s1_super;
  logic [OFF_W-1:0] s1_off;
  logic [ROM_W-1:0] s1_rom;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_region <= RG_RAM;
      s1_write  <= 1'b0;
      s1_super  <= 1'b0;
      s1_off    <= '0;
      s1_rom    <= '0;
    end else begin
      s1_valid <= req_valid;
      if (req_valid) begin
        s1_region <= region0;
        s1_write  <= req_write;
        s1_super  <= req_super;
        s1_off    <= req_addr[OFF_W-1:0];
        s1_rom    <= req_addr[ROM_W-1:0];
      end
    end
  end

  // Stage 1 combinational: rights and address
  logic              chk_fault;
  logic [3:0]        chk_sel;
  logic [PHYS_W-1:0] phys1;

  access_check u_check (
    .region     (s1_region),
    .is_write   (s1_write),
    .is_super   (s1_super),
    .no_access  (entry[NA_BIT]),
    .write_prot (entry[WP_BIT]),
    .fault      (chk_fault),
    .sel        (chk_sel)
  );

  always_comb begin
    phys1 = '0;
    if (!chk_fault) begin
      case (s1_region)
        RG_RAM:  phys1 = {entry[PPAGE_W-1:0], s1_off};
        RG_ROM:  phys1 = PHYS_W'(s1_rom);
        default: phys1 = '0;
      endcase
    end
  end

  // Stage 2: registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_phys    <= '0;
      rsp_sel_ram <= 1'b0;
      rsp_sel_rom <= 1'b0;
      rsp_sel_map <= 1'b0;
      rsp_sel_io  <= 1'b0;
      rsp_fault   <= 1'b0;
    end else begin
      rsp_valid   <= s1_valid;
      rsp_phys    <= s1_valid ? phys1 : '0;
      rsp_sel_ram <= s1_valid && chk_sel[RG_RAM];
      rsp_sel_rom <= s1_valid && chk_sel[RG_ROM];
      rsp_sel_map <= s1_valid && chk_sel[RG_MAP];
      rsp_sel_io  <= s1_valid && chk_sel[RG_IO];
      rsp_fault   <= s1_valid && chk_fault;
    end
  end
endmodule

// File: rtl/mapper_checker.sv
module mapper_checker (
  input logic       clk,
  input logic       rst,
  input logic       s1_valid,
  input logic       s1_super,
  input logic [1:0] s1_region,
  input logic       rsp_valid,
  input logic       rsp_sel_ram,
  input logic       rsp_sel_rom,
  input logic       rsp_sel_map,
  input logic       rsp_sel_io,
  input logic       rsp_fault
);
  a_r10_fault_blocks_sel: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> !(rsp_sel_ram || rsp_sel_rom || rsp_sel_map || rsp_sel_io));

  a_r10_fault_with_valid: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_valid);

  a_r2_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_sel_ram, rsp_sel_rom, rsp_sel_map, rsp_sel_io}));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !rsp_valid);

  a_r8_super_no_fault: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_super) |=> !rsp_fault);

  a_r9_user_io_fault: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_super && s1_region == 2'd3) |=> rsp_fault);
endmodule

bind ctx_page_mapper mapper_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .s1_valid    (s1_valid),
  .s1_super    (s1_super),
  .s1_region   (s1_region),
  .rsp_valid   (rsp_valid),
  .rsp_sel_ram (rsp_sel_ram),
  .rsp_sel_rom (rsp_sel_rom),
  .rsp_sel_map (rsp_sel_map),
  .rsp_sel_io  (rsp_sel_io),
  .rsp_fault   (rsp_fault)
);

// File: tb/tb_ctx_page_mapper.sv
module tb_ctx_page_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_super = 1'b0;
  logic [2:0]  ctx_reg = '0;
  logic [10:0] map_wdata = '0;
  logic        rsp_valid;
  logic [19:0] rsp_phys;
  logic        rsp_sel_ram, rsp_sel_rom, rsp_sel_map, rsp_sel_io, rsp_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        r_valid, r_fault;
  logic [3:0]  r_sel;
  logic [19:0] r_phys;

  always #10 clk = ~clk;

  ctx_page_mapper dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_super(req_super), .ctx_reg(ctx_reg),
    .map_wdata(map_wdata), .rsp_valid(rsp_valid), .rsp_phys(rsp_phys),
    .rsp_sel_ram(rsp_sel_ram), .rsp_sel_rom(rsp_sel_rom),
    .rsp_sel_map(rsp_sel_map), .rsp_sel_io(rsp_sel_io), .rsp_fault(rsp_fault)
  );

  function automatic logic [23:0] ram_a(input logic a21, input logic [9:0] pg, input logic [10:0] off);
    return {2'b00, a21, pg, off};
  endfunction

  function automatic logic [23:0] map_a(input logic [2:0] c, input logic [9:0] pg);
    return {2'b10, 8'h00, c, pg, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // sel order {io, map, rom, ram}
  task automatic access(input logic [23:0] a, input logic wr, input logic sup,
                        input logic [2:0] c, input logic [10:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_super = sup;
    ctx_reg = c; map_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    @(negedge clk);
    r_valid = rsp_valid; r_fault = rsp_fault; r_phys = rsp_phys;
    r_sel = {rsp_sel_io, rsp_sel_map, rsp_sel_rom, rsp_sel_ram};
  endtask

  task automatic t_reset;
    chk("R1 valid in reset", rsp_valid, 0);
    chk("R1 sel in reset", {rsp_sel_io, rsp_sel_map, rsp_sel_rom, rsp_sel_ram}, 0);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 valid after reset", rsp_valid, 0);
    chk("R1 fault after reset", rsp_fault, 0);
  endtask

  task automatic t_map_write;
    access(map_a(3'd0, 10'd5), 1'b1, 1'b1, 3'd6, 11'h123);
    chk("R5 map write select", {r_valid, r_fault, r_sel}, {1'b1, 1'b0, 4'b0100});
    chk("R11 map phys zero", r_phys, 0);
    access(map_a(3'd3, 10'd5), 1'b1, 1'b1, 3'd0, 11'h0AA);
  endtask

  task automatic t_translate;
    access(ram_a(1'b0, 10'd5, 11'h2AB), 1'b0, 1'b1, 3'd3, '0);
    chk("R3 R4 super ctx0 phys", r_phys, {9'h123, 11'h2AB});
    chk("R2 ram select", {r_valid, r_sel}, {1'b1, 4'b0001});
    access(ram_a(1'b1, 10'd5, 11'h7FF), 1'b0, 1'b1, 3'd0, '0);
    chk("R3 bit21 ignored", r_phys, {9'h123, 11'h7FF});
    @(negedge clk);
    chk("R2 valid one cycle", rsp_valid, 0);
  endtask

  task automatic t_context;
    access(ram_a(1'b0, 10'd5, 11'h010), 1'b0, 1'b0, 3'd3, '0);
    chk("R4 user ctx3", r_phys, {9'h0AA, 11'h010});
    access(ram_a(1'b0, 10'd5, 11'h010), 1'b1, 1'b0, 3'd0, '0);
    chk("R4 user ctx0", r_phys, {9'h123, 11'h010});
  endtask

  task automatic t_noaccess;
    access(map_a(3'd2, 10'd7), 1'b1, 1'b1, 3'd0, {1'b1, 1'b0, 9'h055});
    access(ram_a(1'b0, 10'd7, 11'h004), 1'b0, 1'b0, 3'd2, '0);
    chk("R6 user read no-access fault", r_fault, 1);
    chk("R10 fault clears sel and phys", {r_valid, r_sel, r_phys}, {1'b1, 4'b0000, 20'h0});
    access(ram_a(1'b0, 10'd7, 11'h004), 1'b1, 1'b0, 3'd2, '0);
    chk("R6 user write no-access fault", r_fault, 1);
  endtask

  task automatic t_wprot;
    access(map_a(3'd1, 10'd9), 1'b1, 1'b1, 3'd0, {1'b0, 1'b1, 9'h1FF});
    access(ram_a(1'b0, 10'd9, 11'h100), 1'b0, 1'b0, 3'd1, '0);
    chk("R7 user read wp ok", {r_fault, r_sel, r_phys}, {1'b0, 4'b0001, 9'h1FF, 11'h100});
    access(ram_a(1'b0, 10'd9, 11'h100), 1'b1, 1'b0, 3'd1, '0);
    chk("R7 user write wp fault", r_fault, 1);
  endtask

  task automatic t_super_bypass;
    // supervisor uses context 0, so load protected entries there
    access(map_a(3'd0, 10'd20), 1'b1, 1'b1, 3'd0, {1'b1, 1'b1, 9'h033});
    access(ram_a(1'b0, 10'd20, 11'h055), 1'b1, 1'b1, 3'd4, '0);
    chk("R8 super ignores bits", {r_fault, r_sel, r_phys}, {1'b0, 4'b0001, 9'h033, 11'h055});
    access(24'hC00040, 1'b0, 1'b1, 3'd0, '0);
    chk("R8 R2 super io", {r_fault, r_sel}, {1'b0, 4'b1000});
  endtask

  task automatic t_user_regions;
    access(24'hC00040, 1'b0, 1'b0, 3'd0, '0);
    chk("R9 user io fault", {r_fault, r_sel}, {1'b1, 4'b0000});
    access(map_a(3'd0, 10'd5), 1'b1, 1'b0, 3'd0, 11'h7FF);
    chk("R9 user map write fault", r_fault, 1);
    access(map_a(3'd0, 10'd5), 1'b0, 1'b1, 3'd0, 11'h000);
    access(ram_a(1'b0, 10'd5, 11'h001), 1'b0, 1'b1, 3'd0, '0);
    chk("R9 R5 entry untouched", r_phys, {9'h123, 11'h001});
  endtask

  task automatic t_rom;
    access({2'b01, 6'h3F, 16'hBEEF}, 1'b0, 1'b0, 3'd2, '0);
    chk("R11 rom phys", {r_fault, r_sel, r_phys}, {1'b0, 4'b0010, 20'h0BEEF});
  endtask

  initial begin
    t_reset();
    t_map_write();
    t_translate();
    t_context();
    t_noaccess();
    t_wprot();
    t_super_bypass();
    t_user_regions();
    t_rom();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule